// File: doc/BRIEF.md
# Segment Translation Register Bank

This block holds a set of software-loaded region mappings that translate virtual addresses to physical addresses without walking page tables. There are two independent sets: a small set for instruction fetches and a larger set for data accesses. Each mapping is a pair of 32-bit registers. The logical word gives the virtual base of a region. The physical word gives the physical base, a region-size code, three attribute bits and an enable bit.

Each side has a combinational lookup port. The incoming virtual address is compared against every enabled pair of that side at the same time. When a pair matches, the block returns the translated physical address, the pair's attributes and the pair's index. When no pair matches, the result supplied by the TLB for the same access is passed through. A segment hit always takes precedence over the TLB, so both mechanisms can run side by side.

Software reaches the registers through a single write port and a combinational read port. It can remap a temporary page by rewriting only the physical word of a data pair whose logical word was set up once. It can detach that mapping by clearing the physical word, and no TLB flush is needed in either case.

Top module: `sat_xlat_bank`

## Requirements
- R1: Synchronous active-low reset clears every logical and physical register to zero. After reset every read returns 0 and no lookup reports a segment hit.
- R2: A write with `cfg_wr_dside` (0 selects instruction, 1 selects data), `cfg_wr_phys` (0 selects the logical word, 1 selects the physical word) and `cfg_wr_idx` stores `cfg_wr_data` at the next rising edge. The same selection on the read port returns the stored word. An index at or above the side's pair count (8 instruction, 16 data) is not stored and reads back 0.
- R3: The physical word holds the physical base in bits [31:14], the size code s in bits [7:4], the attributes in bits [3:1] and the enable bit in bit 0. A region covers 2^(14+s) bytes, which ranges from 16 KB (s=0) to 512 MB (s=15). A pair hits when it is enabled and bits [31:14+s] of the virtual address equal the same bits of its logical word.
- R4: On a hit, the output address takes bits [31:14+s] from the physical base and the lower bits from the virtual address. The attribute output equals bits [3:1] of the hitting pair's physical word.
- R5: When several enabled pairs match, the pair with the lowest index supplies the result and the index output.
- R6: A pair whose physical word is cleared stops translating, while its logical word keeps its value.
- R7: A segment hit overrides the TLB inputs. On a segment miss, the output address equals the TLB address, the overall hit equals the TLB hit, and the attribute output is 0.
- R8: The instruction and data sides are independent. A write to one side never changes lookups or reads on the other side.
- R9: A lookup always reflects the register contents before the current clock edge. A write issued in the same cycle as a lookup affects that lookup only from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_dside | input | 1 | Write side: 0 instruction, 1 data |
| cfg_wr_phys | input | 1 | Write half: 0 logical, 1 physical |
| cfg_wr_idx | input | 4 | Pair index for the write |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_dside | input | 1 | Read side select |
| cfg_rd_phys | input | 1 | Read half select |
| cfg_rd_idx | input | 4 | Pair index for the read |
| cfg_rd_data | output | 32 | Read data, combinational |
| i_va | input | 32 | Instruction virtual address |
| i_tlb_hit | input | 1 | Instruction TLB hit |
| i_tlb_pa | input | 32 | Instruction TLB physical address |
| i_hit | output | 1 | Instruction translation available |
| i_seg_hit | output | 1 | Instruction segment hit |
| i_seg_idx | output | 3 | Index of the hitting instruction pair |
| i_pa | output | 32 | Instruction physical address |
| i_attr | output | 3 | Instruction segment attributes |
| d_va | input | 32 | Data virtual address |
| d_tlb_hit | input | 1 | Data TLB hit |
| d_tlb_pa | input | 32 | Data TLB physical address |
| d_hit | output | 1 | Data translation available |
| d_seg_hit | output | 1 | Data segment hit |
| d_seg_idx | output | 4 | Index of the hitting data pair |
| d_pa | output | 32 | Data physical address |
| d_attr | output | 3 | Data segment attributes |

## Verification
A software rewrite of a data pair and a lookup that depends on that pair can fall in the same cycle. The bench provokes this by driving the physical-word write and the matching data address together. It judges the lookup twice: before the clock edge it must still show the old miss, and after the edge it must show the hit from the newly attached page. A segment hit and a TLB hit can also coincide. The bench presents both at once and requires that the segment address appears at the output.

// File: rtl/sat_pkg.sv
// Shared field layout and helpers for the segment translation bank.
// Assumes 32-bit addresses and a 16 KB minimum region.
package sat_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned PAGE_SHIFT = 14;
    localparam int unsigned SIZE_LSB   = 4;
    localparam int unsigned SIZE_W     = 4;
    localparam int unsigned ATTR_LSB   = 1;
    localparam int unsigned ATTR_W     = 3;
    localparam int unsigned EN_BIT     = 0;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ATTR_W-1:0] attr_t;
    typedef logic [SIZE_W-1:0] size_t;

    // Mask of the address bits that belong to the region base for size code sz.
    function automatic word_t base_mask(input size_t sz);
        word_t m;
        m = '1;
        m = m << (PAGE_SHIFT + int'(sz));
        return m;
    endfunction
endpackage

// File: rtl/sat_pair_bank.sv
// Storage for N logical/physical register pairs of one side.
// Writes land on the rising edge; reads are combinational.
// Assumes that indices at or above N are silently dropped and read as zero.
module sat_pair_bank
    import sat_pkg::*;
#(
    parameter  int N     = 8,
    parameter  int SEL_W = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_phys,
    input  logic [SEL_W-1:0] wr_idx,
    input  word_t            wr_data,
    input  logic             rd_phys,
    input  logic [SEL_W-1:0] rd_idx,
    output word_t            rd_data,
    output word_t            lreg [N],
    output word_t            preg [N]
);
    logic             wr_ok;
    logic             rd_ok;
    logic [IDX_W-1:0] wi;
    logic [IDX_W-1:0] ri;

    assign wr_ok = int'(wr_idx) < N;
    assign rd_ok = int'(rd_idx) < N;
    assign wi    = wr_idx[IDX_W-1:0];
    assign ri    = rd_idx[IDX_W-1:0];

    // Register update: clear all pairs on reset, else store one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) begin
                lreg[k] <= '0;
                preg[k] <= '0;
            end
        end else if (wr_en && wr_ok) begin
            if (wr_phys) preg[wi] <= wr_data;
            else         lreg[wi] <= wr_data;
        end
    end

    // Read mux: selected half of the selected pair, zero when out of range.
    always_comb begin
        rd_data = '0;
        if (rd_ok) rd_data = rd_phys ? preg[ri] : lreg[ri];
    end
endmodule

// File: rtl/sat_match.sv
// Parallel comparison of one virtual address against N pairs.
// The lowest-numbered enabled matching pair wins.
// Assumes the register layout defined in sat_pkg.
module sat_match
    import sat_pkg::*;
#(
    parameter  int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  word_t            va,
    input  word_t            lreg [N],
    input  word_t            preg [N],
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output word_t            pa,
    output attr_t            attr
);
    logic  [N-1:0] hit_vec;
    word_t         mask [N];

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign mask[g]    = base_mask(preg[g][SIZE_LSB +: SIZE_W]);
        assign hit_vec[g] = preg[g][EN_BIT] && (((va ^ lreg[g]) & mask[g]) == '0);
    end

    // Priority select: scanning downward leaves the lowest matching index.
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        pa   = '0;
        attr = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (hit_vec[k]) begin
                hit  = 1'b1;
                idx  = IDX_W'(k);
                pa   = (preg[k] & mask[k]) | (va & ~mask[k]);
                attr = preg[k][ATTR_LSB +: ATTR_W];
            end
        end
    end
endmodule

// File: rtl/sat_xlat_bank.sv
// Top of the segment translation bank: an instruction set and a data set of
// register pairs, a shared software port and one lookup port per side.
// A segment hit overrides the TLB result presented on the same side.
module sat_xlat_bank
    import sat_pkg::*;
#(
    parameter  int I_PAIRS = 8,
    parameter  int D_PAIRS = 16,
    parameter  int SEL_W   = 4,
    localparam int I_IDX_W = $clog2(I_PAIRS),
    localparam int D_IDX_W = $clog2(D_PAIRS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic               cfg_wr_dside,
    input  logic               cfg_wr_phys,
    input  logic [SEL_W-1:0]   cfg_wr_idx,
    input  logic [31:0]        cfg_wr_data,
    input  logic               cfg_rd_dside,
    input  logic               cfg_rd_phys,
    input  logic [SEL_W-1:0]   cfg_rd_idx,
    output logic [31:0]        cfg_rd_data,
    input  logic [31:0]        i_va,
    input  logic               i_tlb_hit,
    input  logic [31:0]        i_tlb_pa,
    output logic               i_hit,
    output logic               i_seg_hit,
    output logic [I_IDX_W-1:0] i_seg_idx,
    output logic [31:0]        i_pa,
    output logic [2:0]         i_attr,
    input  logic [31:0]        d_va,
    input  logic               d_tlb_hit,
    input  logic [31:0]        d_tlb_pa,
    output logic               d_hit,
    output logic               d_seg_hit,
    output logic [D_IDX_W-1:0] d_seg_idx,
    output logic [31:0]        d_pa,
    output logic [2:0]         d_attr
);
    word_t i_lreg [I_PAIRS];
    word_t i_preg [I_PAIRS];
    word_t d_lreg [D_PAIRS];
    word_t d_preg [D_PAIRS];
    word_t i_rd, d_rd, i_seg_pa, d_seg_pa;

    sat_pair_bank #(.N(I_PAIRS), .SEL_W(SEL_W)) u_ibank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en && !cfg_wr_dside), .wr_phys(cfg_wr_phys),
        .wr_idx(cfg_wr_idx), .wr_data(cfg_wr_data),
        .rd_phys(cfg_rd_phys), .rd_idx(cfg_rd_idx), .rd_data(i_rd),
        .lreg(i_lreg), .preg(i_preg)
    );

    sat_pair_bank #(.N(D_PAIRS), .SEL_W(SEL_W)) u_dbank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en && cfg_wr_dside), .wr_phys(cfg_wr_phys),
        .wr_idx(cfg_wr_idx), .wr_data(cfg_wr_data),
        .rd_phys(cfg_rd_phys), .rd_idx(cfg_rd_idx), .rd_data(d_rd),
        .lreg(d_lreg), .preg(d_preg)
    );

    sat_match #(.N(I_PAIRS)) u_imatch (
        .va(i_va), .lreg(i_lreg), .preg(i_preg),
        .hit(i_seg_hit), .idx(i_seg_idx), .pa(i_seg_pa), .attr(i_attr)
    );

    sat_match #(.N(D_PAIRS)) u_dmatch (
        .va(d_va), .lreg(d_lreg), .preg(d_preg),
        .hit(d_seg_hit), .idx(d_seg_idx), .pa(d_seg_pa), .attr(d_attr)
    );

    // Software read: pick the bank named by the read side select.
    assign cfg_rd_data = cfg_rd_dside ? d_rd : i_rd;

    // Merge with the TLB: a segment hit wins, otherwise the TLB passes through.
    assign i_hit = i_seg_hit || i_tlb_hit;
    assign i_pa  = i_seg_hit ? i_seg_pa : i_tlb_pa;
    assign d_hit = d_seg_hit || d_tlb_hit;
    assign d_pa  = d_seg_hit ? d_seg_pa : d_tlb_pa;
endmodule

// File: rtl/sat_xlat_chk.sv
// Assertion checker for sat_xlat_bank, attached through bind.
// Assumes it observes the top-level ports only.
module sat_xlat_chk #(
    parameter  int I_PAIRS = 8,
    parameter  int D_PAIRS = 16,
    parameter  int SEL_W   = 4,
    localparam int I_IDX_W = $clog2(I_PAIRS),
    localparam int D_IDX_W = $clog2(D_PAIRS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wr_en,
    input logic               cfg_wr_dside,
    input logic               cfg_wr_phys,
    input logic [SEL_W-1:0]   cfg_wr_idx,
    input logic [31:0]        cfg_wr_data,
    input logic               cfg_rd_dside,
    input logic               cfg_rd_phys,
    input logic [SEL_W-1:0]   cfg_rd_idx,
    input logic [31:0]        cfg_rd_data,
    input logic [31:0]        i_va,
    input logic               i_tlb_hit,
    input logic [31:0]        i_tlb_pa,
    input logic               i_hit,
    input logic               i_seg_hit,
    input logic [I_IDX_W-1:0] i_seg_idx,
    input logic [31:0]        i_pa,
    input logic [2:0]         i_attr,
    input logic [31:0]        d_va,
    input logic               d_tlb_hit,
    input logic [31:0]        d_tlb_pa,
    input logic               d_hit,
    input logic               d_seg_hit,
    input logic [D_IDX_W-1:0] d_seg_idx,
    input logic [31:0]        d_pa,
    input logic [2:0]         d_attr
);
    logic primed = 1'b0;
    logic wr_lands;

    // Marks that at least one clock edge has been seen.
    always_ff @(posedge clk) primed <= 1'b1;

    assign wr_lands = cfg_wr_en &&
                      (int'(cfg_wr_idx) < (cfg_wr_dside ? D_PAIRS : I_PAIRS));

    AST_RESET_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !$past(rst_n)) |-> (!i_seg_hit && !d_seg_hit)); // R1

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lands |=> ((cfg_rd_dside != $past(cfg_wr_dside)) ||
                      (cfg_rd_phys  != $past(cfg_wr_phys))  ||
                      (cfg_rd_idx   != $past(cfg_wr_idx))   ||
                      (cfg_rd_data  == $past(cfg_wr_data)))); // R2

    AST_DATA_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        d_seg_hit |-> (d_pa[13:0] == d_va[13:0])); // R4

    AST_INST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        i_seg_hit |-> (i_pa[13:0] == i_va[13:0])); // R4

    AST_DATA_TLB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !d_seg_hit |-> (d_hit == d_tlb_hit && d_pa == d_tlb_pa && d_attr == 3'd0)); // R7

    AST_INST_TLB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !i_seg_hit |-> (i_hit == i_tlb_hit && i_pa == i_tlb_pa && i_attr == 3'd0)); // R7
endmodule

bind sat_xlat_bank sat_xlat_chk #(
    .I_PAIRS(I_PAIRS), .D_PAIRS(D_PAIRS), .SEL_W(SEL_W)
) u_sat_xlat_chk (.*);

// File: tb/test_sat_xlat_bank.sv
module test_sat_xlat_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0, cfg_wr_dside = 1'b0, cfg_wr_phys = 1'b0;
    logic [3:0]  cfg_wr_idx = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        cfg_rd_dside = 1'b0, cfg_rd_phys = 1'b0;
    logic [3:0]  cfg_rd_idx = '0;
    logic [31:0] cfg_rd_data;
    logic [31:0] i_va = '0, i_tlb_pa = '0, i_pa;
    logic        i_tlb_hit = 1'b0, i_hit, i_seg_hit;
    logic [2:0]  i_seg_idx, i_attr;
    logic [31:0] d_va = '0, d_tlb_pa = '0, d_pa;
    logic        d_tlb_hit = 1'b0, d_hit, d_seg_hit;
    logic [3:0]  d_seg_idx;
    logic [2:0]  d_attr;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    sat_xlat_bank i_sat_xlat_bank (.*);

    typedef struct packed {
        logic        dside;
        logic [31:0] va;
        logic        tlb_hit;
        logic [31:0] tlb_pa;
        logic        exp_hit;
        logic        exp_seg;
        logic [3:0]  exp_idx;
        logic [31:0] exp_pa;
        logic [2:0]  exp_attr;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'hC1234567, 1'b0, 32'h0,         1'b1, 1'b1, 4'd0,  32'h01234567, 3'd5}, // R3 R4 256MB
        '{1'b1, 32'hDD0812AB, 1'b0, 32'h0,         1'b1, 1'b1, 4'd3,  32'h005352AB, 3'd3}, // R5 16KB overlap
        '{1'b1, 32'hF8765432, 1'b0, 32'h0,         1'b1, 1'b1, 4'd11, 32'hF8765432, 3'd7}, // R3 512MB
        '{1'b1, 32'h00100000, 1'b1, 32'h12345678,  1'b1, 1'b0, 4'd0,  32'h12345678, 3'd0}, // R7 tlb pass
        '{1'b1, 32'hC0000010, 1'b1, 32'hAAAAAAAA,  1'b1, 1'b1, 4'd0,  32'h00000010, 3'd5}, // R7 seg wins
        '{1'b1, 32'h00100000, 1'b0, 32'h0,         1'b0, 1'b0, 4'd0,  32'h0,        3'd0}, // R7 full miss
        '{1'b0, 32'hC0ABCDEF, 1'b0, 32'h0,         1'b1, 1'b1, 4'd0,  32'h00ABCDEF, 3'd2}, // R4 inst
        '{1'b0, 32'h010712AB, 1'b0, 32'h0,         1'b1, 1'b1, 4'd1,  32'h006F92AB, 3'd1}, // R3 inst pair 1
        '{1'b0, 32'hDD0812AB, 1'b0, 32'h0,         1'b0, 1'b0, 4'd0,  32'h0,        3'd0}, // R8 data-only map
        '{1'b0, 32'hE0000000, 1'b0, 32'h0,         1'b0, 1'b0, 4'd0,  32'h0,        3'd0}  // R3 inst miss
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic dside, input logic phys, input logic [3:0] idx,
                      input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_dside = dside; cfg_wr_phys = phys;
        cfg_wr_idx = idx; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic dside, input logic phys,
                            input logic [3:0] idx, input logic [31:0] exp);
        cfg_rd_dside = dside; cfg_rd_phys = phys; cfg_rd_idx = idx;
        #1;
        check(req, "readback", cfg_rd_data, exp);
    endtask

    task automatic d_look(input string req, input logic [31:0] va, input logic seg,
                          input logic [3:0] idx, input logic [31:0] pa, input logic [2:0] at);
        d_va = va; d_tlb_hit = 1'b0; d_tlb_pa = '0;
        #1;
        check(req, "d_seg_hit", 32'(d_seg_hit), 32'(seg));
        check(req, "d_seg_idx", 32'(d_seg_idx), 32'(idx));
        check(req, "d_pa", d_pa, pa);
        check(req, "d_attr", 32'(d_attr), 32'(at));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: all registers empty, no hits after reset
        rd_check("R1", 1'b1, 1'b1, 4'd0, 32'h0);
        rd_check("R1", 1'b0, 1'b0, 4'd7, 32'h0);
        d_look("R1", 32'h00000000, 1'b0, 4'd0, 32'h0, 3'd0);

        // Load the mappings used by the table.
        wr(1'b1, 1'b0, 4'd0,  32'hC0000000); wr(1'b1, 1'b1, 4'd0,  32'h000000EB);
        wr(1'b1, 1'b0, 4'd3,  32'hDD080000); wr(1'b1, 1'b1, 4'd3,  32'h00534007);
        wr(1'b1, 1'b0, 4'd5,  32'hDD080000); wr(1'b1, 1'b1, 4'd5,  32'h00700003);
        wr(1'b1, 1'b0, 4'd11, 32'hE0000000); wr(1'b1, 1'b1, 4'd11, 32'hE00000FF);
        wr(1'b0, 1'b0, 4'd0,  32'hC0000000); wr(1'b0, 1'b1, 4'd0,  32'h000000E5);
        wr(1'b0, 1'b0, 4'd1,  32'h01070000); wr(1'b0, 1'b1, 4'd1,  32'h006F8003);
        // R2: readback of stored words
        rd_check("R2", 1'b1, 1'b1, 4'd11, 32'hE00000FF);
        rd_check("R2", 1'b0, 1'b0, 4'd1,  32'h01070000);

        for (int v = 0; v < NV; v++) begin
            d_va = VECS[v].dside ? VECS[v].va : 32'h0;
            d_tlb_hit = VECS[v].dside ? VECS[v].tlb_hit : 1'b0;
            d_tlb_pa = VECS[v].dside ? VECS[v].tlb_pa : 32'h0;
            i_va = VECS[v].dside ? 32'h0 : VECS[v].va;
            i_tlb_hit = VECS[v].dside ? 1'b0 : VECS[v].tlb_hit;
            i_tlb_pa = VECS[v].dside ? 32'h0 : VECS[v].tlb_pa;
            #1;
            if (VECS[v].dside) begin
                check("R3/R4/R5/R7 vec", "d_hit", 32'(d_hit), 32'(VECS[v].exp_hit));
                check("R3/R4/R5/R7 vec", "d_seg_hit", 32'(d_seg_hit), 32'(VECS[v].exp_seg));
                check("R5 vec", "d_seg_idx", 32'(d_seg_idx), 32'(VECS[v].exp_idx));
                check("R4 vec", "d_pa", d_pa, VECS[v].exp_pa);
                check("R4 vec", "d_attr", 32'(d_attr), 32'(VECS[v].exp_attr));
            end else begin
                check("R3/R8 vec", "i_hit", 32'(i_hit), 32'(VECS[v].exp_hit));
                check("R3/R8 vec", "i_seg_hit", 32'(i_seg_hit), 32'(VECS[v].exp_seg));
                check("R5 vec", "i_seg_idx", 32'(i_seg_idx), VECS[v].exp_idx);
                check("R4 vec", "i_pa", i_pa, VECS[v].exp_pa);
                check("R4 vec", "i_attr", 32'(i_attr), 32'(VECS[v].exp_attr));
            end
            @(negedge clk);
        end
        i_va = '0;

        // R2 R8: out-of-range instruction index is dropped, data side untouched
        wr(1'b0, 1'b0, 4'd9, 32'hDEADBEEF);
        rd_check("R2", 1'b0, 1'b0, 4'd9, 32'h0);
        rd_check("R8", 1'b1, 1'b0, 4'd9, 32'h0);

        // R6: clearing the physical word detaches pair 3, pair 5 now wins
        wr(1'b1, 1'b1, 4'd3, 32'h0);
        d_look("R6", 32'hDD0812AB, 1'b1, 4'd5, 32'h007012AB, 3'd1);
        rd_check("R6", 1'b1, 1'b0, 4'd3, 32'hDD080000);
        wr(1'b1, 1'b1, 4'd5, 32'h0);
        d_look("R6", 32'hDD0812AB, 1'b0, 4'd0, 32'h0, 3'd0);

        // R9: write and lookup in the same cycle
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_dside = 1'b1; cfg_wr_phys = 1'b1;
        cfg_wr_idx = 4'd3; cfg_wr_data = 32'h00534007;
        d_va = 32'hDD0812AB;
        #1;
        check("R9", "d_seg_hit before edge", 32'(d_seg_hit), 32'd0);
        @(posedge clk);
        #1;
        check("R9", "d_seg_hit after edge", 32'(d_seg_hit), 32'd1);
        check("R9", "d_pa after edge", d_pa, 32'h005352AB);
        @(negedge clk);
        cfg_wr_en = 1'b0;

        // R1: a second reset removes every mapping
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        d_look("R1", 32'hC1234567, 1'b0, 4'd0, 32'h0, 3'd0);
        rd_check("R1", 1'b1, 1'b1, 4'd0, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule